// File: doc/BRIEF.md
# CRC-4 Submultiframe Error Checker

This block checks the CRC-4 protection of an E1 receive bit stream that an upstream synchronizer has already aligned to the multiframe. Bits arrive one at a time with a valid strobe, and a marker flags the first bit of every multiframe. Over each submultiframe (eight frames) the block computes a 4-bit remainder with the generator x^4 + x + 1. The register starts from zero at the first bit of each submultiframe, and the four check-bit positions are fed in as zeros.

The remainder is held for a whole submultiframe, because the check bits that protect a submultiframe are carried in the submultiframe that follows it. At the end of that following submultiframe the four received check bits are compared with the held remainder. A mismatch in any number of the four bits adds exactly one to a saturating error counter. Software-side logic reads the counter through a read strobe, and each read also clears it. Checking stops while the enable is low. After enable rises, or after the multiframe marker shows up at an unexpected position, the block waits one full submultiframe before it makes any comparison.

Top module: `crc4_smf_checker`

## Requirements
- R1: After reset the read data output and the internal error count are zero.
- R2: A submultiframe whose four received check bits equal the remainder of the previous submultiframe leaves the count unchanged.
- R3: A submultiframe whose check bits differ from the previous remainder in one, several or all four positions adds exactly one to the count.
- R4: Check bits sit at bit 0 (first bit) of frames 0, 2, 4 and 6 of a submultiframe and carry remainder bits 3, 2, 1 and 0 in that order. They are treated as zero when the remainder is computed. The remainder is the stream times x^4 modulo x^4 + x + 1, processed first bit first.
- R5: No comparison is made in the first submultiframe after alignment is gained.
- R6: A multiframe marker that arrives when the position counters are not at a multiframe start realigns the block and discards the held remainder. A marker at the expected position changes nothing.
- R7: Cycles with the valid strobe low are ignored: they do not advance the position or the remainder, and they do not change the count.
- R8: While enable is low nothing is counted and alignment is lost. After enable returns, bits are ignored until the next multiframe marker.
- R9: A read strobe makes the counter value appear on the read data output one cycle later and clears the counter. An error detected in the same cycle as the read leaves the counter at one.
- R10: The count saturates at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | CRC-4 checking enabled (multiframe format with CRC-4 selected) |
| rx_bit | input | 1 | Serial receive data bit |
| rx_valid | input | 1 | rx_bit carries a stream bit this cycle |
| mf_start | input | 1 | Current valid bit is the first bit of a multiframe |
| rd_en | input | 1 | Read strobe: capture and clear the error count |
| rd_data | output | CNT_W (16) | Error count captured by the last read |

## Verification
The bench models the check with its own remainder calculation, so a design that takes the check bits into the remainder, uses them in reversed order, or compares them with the current submultiframe instead of the previous one drifts away from the expected counts. It drives several mismatches with four wrong bits to catch a design that counts bits rather than submultiframes. It also drives the first submultiframe after alignment, after re-enable and after a misplaced marker with wrong check bits, so a design that keeps a stale remainder shows spurious errors. Valid gaps, a read in the same cycle as an error, and a run past saturation expose designs that advance on idle cycles, lose the coinciding error, or wrap to zero.

// File: rtl/crc4_pkg.sv
// Shared types and the CRC-4 step function for the submultiframe checker.
package crc4_pkg;

    // Per-bit position strobes from the timer to the CRC datapath.
    typedef struct packed {
        logic       act;      // this cycle carries an aligned stream bit
        logic       first;    // first bit of a submultiframe
        logic       last;     // last bit of a submultiframe
        logic       is_chk;   // bit is a check-bit slot
        logic [1:0] chk_idx;  // which check bit (0 = most significant)
        logic       restart;  // marker seen off the expected position
    } pos_t;

    // One serial step of the x^4 + x + 1 divider, message multiplied by x^4.
    function automatic logic [3:0] crc4_step(input logic [3:0] r, input logic b);
        logic fb;
        fb = b ^ r[3];
        return {r[2:0], 1'b0} ^ {2'b00, fb, fb};
    endfunction

endpackage

// File: rtl/crc4_smf_timer.sv
// Position tracker: counts bits, frames and submultiframe halves of the
// aligned stream and derives the per-bit strobes for the CRC datapath.
// Assumes SMF_FRAMES >= 8 and that mf_start only comes with a valid bit.
module crc4_smf_timer
    import crc4_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int SMF_FRAMES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rx_valid,
    input  logic mf_start,
    output pos_t pos
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam int FW = $clog2(SMF_FRAMES);
    localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);
    localparam logic [FW-1:0] FRM_LAST = FW'(SMF_FRAMES - 1);
    localparam logic [FW-1:0] CHK_FRAMES = FW'(4);

    logic [BW-1:0] bit_q, cur_bit;
    logic [FW-1:0] frm_q, cur_frm, frm_pair;
    logic          half_q, cur_half, aligned_q, act;

    // Current position: the marker forces the start of a multiframe.
    always_comb begin
        act      = enable && rx_valid && (aligned_q || mf_start);
        cur_bit  = mf_start ? '0 : bit_q;
        cur_frm  = mf_start ? '0 : frm_q;
        cur_half = mf_start ? 1'b0 : half_q;
        frm_pair = cur_frm >> 1;
        pos.act     = act;
        pos.first   = act && (cur_bit == '0) && (cur_frm == '0);
        pos.last    = act && (cur_bit == BIT_LAST) && (cur_frm == FRM_LAST);
        pos.is_chk  = act && (cur_bit == '0) && !cur_frm[0] && (frm_pair < CHK_FRAMES);
        pos.chk_idx = frm_pair[1:0];
        pos.restart = act && mf_start && aligned_q &&
                      ((bit_q != '0) || (frm_q != '0) || half_q);
    end

    // Advance the position on every aligned bit; drop alignment when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            bit_q     <= '0;
            frm_q     <= '0;
            half_q    <= 1'b0;
            aligned_q <= 1'b0;
        end else if (act) begin
            aligned_q <= 1'b1;
            if (cur_bit == BIT_LAST) begin
                bit_q <= '0;
                if (cur_frm == FRM_LAST) begin
                    frm_q  <= '0;
                    half_q <= !cur_half;
                end else begin
                    frm_q  <= cur_frm + FW'(1);
                    half_q <= cur_half;
                end
            end else begin
                bit_q  <= cur_bit + BW'(1);
                frm_q  <= cur_frm;
                half_q <= cur_half;
            end
        end
    end

endmodule

// File: rtl/crc4_smf_crc.sv
// CRC datapath: accumulates the remainder of the running submultiframe,
// captures its received check bits and compares them with the remainder
// held from the previous submultiframe. Assumes strobes from the timer.
module crc4_smf_crc
    import crc4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic rx_bit,
    input  pos_t pos,
    output logic err_pulse
);
    logic [3:0] crc_q, crc_base, crc_d;
    logic [3:0] rx_chk_q, prev_q;
    logic       have_prev_q;
    logic [1:0] chk_slot;

    // Next remainder, with check slots fed as zero; mismatch at the boundary.
    always_comb begin
        crc_base  = pos.first ? 4'h0 : crc_q;
        crc_d     = crc4_step(crc_base, pos.is_chk ? 1'b0 : rx_bit);
        chk_slot  = 2'd3 - pos.chk_idx;
        err_pulse = pos.last && have_prev_q && (rx_chk_q != prev_q);
    end

    // Remainder, received check bits and the held previous remainder.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            crc_q       <= 4'h0;
            rx_chk_q    <= 4'h0;
            prev_q      <= 4'h0;
            have_prev_q <= 1'b0;
        end else if (pos.act) begin
            crc_q <= crc_d;
            if (pos.is_chk)
                rx_chk_q[chk_slot] <= rx_bit;
            if (pos.last) begin
                prev_q      <= crc_d;
                have_prev_q <= 1'b1;
            end
            if (pos.restart)
                have_prev_q <= 1'b0;
        end
    end

endmodule

// File: rtl/crc4_err_cnt.sv
// Saturating error counter with read-and-clear. A read returns the count
// one cycle later; an error in the read cycle restarts the count at one.
module crc4_err_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             rd_en,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] rd_data
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count errors, capture and clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= cnt;
            cnt     <= inc ? CNT_W'(1) : '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/crc4_smf_checker.sv
// Top level of the CRC-4 submultiframe checker: position timer, CRC
// datapath and error counter. Assumes the stream is multiframe aligned.
module crc4_smf_checker #(
    parameter int FRAME_BITS = 256,
    parameter int SMF_FRAMES = 8,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             rx_bit,
    input  logic             rx_valid,
    input  logic             mf_start,
    input  logic             rd_en,
    output logic [CNT_W-1:0] rd_data
);
    crc4_pkg::pos_t   pos;
    logic             err_pulse;
    logic [CNT_W-1:0] err_cnt;

    crc4_smf_timer #(.FRAME_BITS(FRAME_BITS), .SMF_FRAMES(SMF_FRAMES)) u_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rx_valid(rx_valid),
        .mf_start(mf_start), .pos(pos)
    );

    crc4_smf_crc u_crc (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rx_bit(rx_bit),
        .pos(pos), .err_pulse(err_pulse)
    );

    crc4_err_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(err_pulse), .rd_en(rd_en),
        .cnt(err_cnt), .rd_data(rd_data)
    );

endmodule

// File: rtl/crc4_smf_checker_sva.sv
// Property checker for the CRC-4 submultiframe checker, bound to the top.
module crc4_smf_checker_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             rx_valid,
    input logic             rd_en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] rd_data
);
    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt && !rd_en) |=> &cnt);

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)));

    // R9
    read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data == $past(cnt)) && (cnt <= CNT_W'(1)));

    // R9
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !rd_en) |=> $stable(cnt));

    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !rd_en) |=> $stable(cnt));

endmodule

bind crc4_smf_checker crc4_smf_checker_sva #(.CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rx_valid(rx_valid),
    .rd_en(rd_en), .cnt(err_cnt), .rd_data(rd_data)
);

// File: tb/crc4_smf_checker_bench.sv
// Scoreboard bench: driver tasks model expected counts and queue them on
// each read; a monitor pops and compares read data as it appears.
module crc4_smf_checker_bench;
    localparam int FB   = 16;
    localparam int SF   = 8;
    localparam int CW   = 4;
    localparam int SMFB = FB * SF;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          rx_bit = 1'b0;
    logic          rx_valid = 1'b0;
    logic          mf_start = 1'b0;
    logic          rd_en = 1'b0;
    logic [CW-1:0] rd_data;
    logic          rd_q = 1'b0;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];

    // bench model state
    int         m_cnt = 0;
    bit         m_aligned = 0;
    bit         m_have = 0;
    bit         m_half = 0;
    logic [3:0] m_prev = 4'h0;

    always #10 clk = ~clk;

    crc4_smf_checker #(.FRAME_BITS(FB), .SMF_FRAMES(SF), .CNT_W(CW)) u_crc4_smf_checker (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rx_bit(rx_bit),
        .rx_valid(rx_valid), .mf_start(mf_start), .rd_en(rd_en), .rd_data(rd_data)
    );

    always @(posedge clk) rd_q <= rd_en;

    // monitor: compare read data one cycle after each read strobe
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                errors++; checks++;
                $display("FAIL unexpected read: actual %0d expected none", rd_data);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (int'(rd_data) != e) begin
                    errors++;
                    $display("FAIL %s: read count actual %0d expected %0d", t, rd_data, e);
                end
            end
        end
    end

    function automatic logic [3:0] step(input logic [3:0] r, input logic b);
        logic [4:0] s;
        s = {r, b ^ 1'b0} ;
        // divide by x^4 + x + 1 (10011): shift in zero-extended, reduce
        s = {r, 1'b0};
        if (r[3] ^ b) s = s ^ 5'b10011;
        return s[3:0];
    endfunction

    function automatic bit is_chk_pos(input int i);
        int f, b;
        f = i / FB;
        b = i % FB;
        return (b == 0) && (f % 2 == 0) && (f < 8);
    endfunction

    task automatic do_read(input string tag);
        exp_q.push_back(m_cnt);
        tag_q.push_back(tag);
        m_cnt = 0;
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    // drive one submultiframe; flip corrupts the correct check bits
    task automatic send_smf(input bit with_mf, input logic [3:0] flip,
                            input bit gaps, input bit rd_last, input string tag);
        logic bits [SMFB];
        logic [3:0] chk, rem;
        bit counted;
        counted = with_mf || m_aligned;
        if (with_mf && m_half) m_have = 0;
        if (with_mf) begin m_half = 0; m_aligned = 1; end
        chk = (m_have ? m_prev : 4'($urandom)) ^ flip;
        rem = 4'h0;
        for (int i = 0; i < SMFB; i++) begin
            if (is_chk_pos(i)) bits[i] = chk[3 - (i / FB) / 2];
            else bits[i] = 1'($urandom);
            rem = step(rem, is_chk_pos(i) ? 1'b0 : bits[i]);
        end
        if (rd_last) begin
            exp_q.push_back(m_cnt);
            tag_q.push_back(tag);
            m_cnt = 0;
        end
        if (counted) begin
            if (m_have && flip != 4'h0) m_cnt = (m_cnt < CMAX) ? m_cnt + 1 : CMAX;
            m_prev = rem;
            m_have = 1;
            m_half = !m_half;
        end
        for (int i = 0; i < SMFB; i++) begin
            @(negedge clk);
            rx_bit   = bits[i];
            rx_valid = 1'b1;
            mf_start = with_mf && (i == 0);
            rd_en    = rd_last && (i == SMFB - 1);
            if (gaps && (i % 7 == 3)) begin
                @(negedge clk);
                rx_valid = 1'b0;
                mf_start = 1'b0;
                rx_bit   = 1'($urandom);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        mf_start = 1'b0;
        rd_en    = 1'b0;
    endtask

    // drive a partial submultiframe, leaving the design mid-position
    task automatic send_partial(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_bit = 1'($urandom);
            rx_valid = 1'b1;
        end
        @(negedge clk) rx_valid = 1'b0;
        m_have = 0;
        m_half = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rd_data !== '0) begin
            errors++;
            $display("FAIL R1: reset rd_data actual %0d expected 0", rd_data);
        end
        do_read("R1");
        enable = 1'b1;

        // R5: first submultiframe with wrong bits is not compared
        send_smf(1, 4'hF, 0, 0, "");
        do_read("R5");
        // R2 / R7: clean submultiframes with valid gaps
        send_smf(0, 4'h0, 1, 0, "");
        send_smf(1, 4'h0, 1, 0, "");
        send_smf(0, 4'h0, 0, 0, "");
        do_read("R2 R7");
        // R3 / R4: one bit, all bits, single MSB and LSB corruptions
        send_smf(1, 4'h1, 0, 0, "");
        send_smf(0, 4'hF, 1, 0, "");
        do_read("R3");
        send_smf(1, 4'h8, 0, 0, "");
        send_smf(0, 4'h6, 0, 0, "");
        send_smf(1, 4'h0, 0, 0, "");
        do_read("R4");

        // R6: misplaced marker discards held remainder
        send_partial(37);
        send_smf(1, 4'hF, 0, 0, "");
        send_smf(0, 4'h0, 0, 0, "");
        do_read("R6 realign");
        // R6: marker at expected position keeps comparison
        send_smf(1, 4'h0, 0, 0, "");
        send_smf(0, 4'h2, 0, 0, "");
        do_read("R6 expected marker");

        // R8: disable, then bits ignored until marker
        repeat (4) @(negedge clk);
        enable = 1'b0;
        m_aligned = 0; m_have = 0; m_half = 0;
        repeat (5) @(negedge clk);
        enable = 1'b1;
        send_smf(0, 4'h1, 0, 0, "");
        send_smf(1, 4'h1, 0, 0, "");
        send_smf(0, 4'h0, 0, 0, "");
        do_read("R8 reenable");
        send_smf(1, 4'h4, 0, 0, "");
        do_read("R8 counting resumes");

        // R9: read in the same cycle as an error
        send_smf(0, 4'h1, 0, 0, "");
        send_smf(1, 4'h3, 0, 1, "R9 collision read");
        do_read("R9 after collision");

        // R10: saturation
        for (int k = 0; k < CMAX + 3; k++) send_smf(!m_half, 4'h9, k % 3 == 0, 0, "");
        do_read("R10");
        send_smf(!m_half, 4'h0, 0, 0, "");
        do_read("R10 cleared");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++; checks++;
            $display("FAIL R9: pending reads actual %0d expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule